// File: doc/BRIEF.md
# Output channel mapper and rescaler

This block drives thirty-two DAC channels from a bus of single-precision floating-point model signals. Each channel is assigned a source signal through a programmable index. It scales that value by its own gain and adds its own offset. It then converts the result to a 16-bit unsigned code with 11 fractional bits, clamping anything out of range. The channels form two banks of sixteen, and each bank has its own conversion strobe for its DAC interface.

A one-bit sync pulse sets the sample period. On an accepted pulse, the block snapshots the signal bus and commits any pending configuration writes. It then sweeps the channels in order through one shared, pipelined scale-and-convert datapath. Each bank's outputs change together once all sixteen of its results are ready. In the same cycle that bank's strobe rises for one cycle. A park input, sampled at the sync pulse, makes that sample all zero codes, so the outputs fall to zero at the next update rather than at once.

Configuration goes through a small write port. The port selects a channel, a field (source index, gain or offset) and a 32-bit value. Writes land in shadow registers and only reach the datapath at the next accepted sync.

Top module: `dac_chmap`

## Requirements
- R1: A channel whose source index is `i`, with `i` below NUM_SIG, takes its input from bits `[32*i+31 : 32*i]` of `sig_bus_i`.
- R2: The code is floor((x*gain + offset) * 2048) when the result lies in [0, 32). Here x, gain and offset are IEEE-754 single values. The result is exact when every operand and intermediate value is a multiple of 2^-16 below 2^23 in magnitude.
- R3: Results below zero, including minus infinity, give code 0x0000. Results of 32 or more, including plus infinity, give 0xFFFF.
- R4: If the source, the gain or the offset is a NaN, the channel code is 0x0000.
- R5: A source index of NUM_SIG or more reads a constant zero, so the code equals the converted offset.
- R6: `cfg_field_i` selects the field written when `cfg_we_i` is high: 0 = source index (low IDX_W bits of `cfg_data_i`), 1 = gain, 2 = offset, 3 = no effect. A write changes no output until the next accepted sync pulse.
- R7: The signal bus is sampled on the clock edge where a sync pulse is accepted. Changes after that edge do not affect that sample. Channel outputs hold their values between bank updates.
- R8: After an accepted sync edge, bank 0 (channels 0..15) updates and `conv_o[0]` is high for exactly one cycle starting 19 clock edges later. Bank 1 (channels 16..31) does the same 35 edges later with `conv_o[1]`. The two strobes are never high together.
- R9: If `park_i` is high on the accepted sync edge, every channel code of that sample is 0x0000. The following sample is computed normally.
- R10: A sync pulse arriving on any of the 32 edges after an accepted one is ignored.
- R11: After reset every channel code is 0x0000 and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Sample sync pulse |
| park_i | input | 1 | Zero the next sample, sampled at sync |
| sig_bus_i | input | NUM_SIG*32 | Packed single-precision source signals, index 0 in the low bits |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_field_i | input | 2 | Field select: 0 index, 1 gain, 2 offset |
| cfg_ch_i | input | 5 | Channel addressed by the write |
| cfg_data_i | input | 32 | Write value |
| ch_code_o | output | NUM_CH*16 | Channel codes, channel n at bits [16n+15:16n] |
| conv_o | output | 2 | Per-bank conversion strobe |

## Verification
Any fault in the sweep counter, the pipeline tags or the staging store shows up as a wrong or missing code at a bank update. For bank 0 that update comes 19 cycles after the sync edge, and for bank 1 it comes 35 cycles after. A fault in the shadow-to-active commit or the snapshot shows only once a later sample is taken. For that reason the bench writes configuration and changes the bus between pulses, then compares the sample that follows. A stuck strobe or a strobe in the wrong cycle is caught at the first sync.

// File: rtl/dac_chmap_pkg.sv
package dac_chmap_pkg;

  localparam int FXW       = 40;          // internal signed fixed width
  localparam int FRAC      = 16;          // internal fractional bits
  localparam int SW        = 2 * FXW;     // product / sum width
  localparam int CODE_W    = 16;
  localparam int CODE_FRAC = 11;

  typedef logic signed [FXW-1:0] fx_t;
  typedef logic signed [SW-1:0]  wide_t;
  typedef logic [CODE_W-1:0]     code_t;

  function automatic logic f_is_nan(input logic [31:0] f);
    return (f[30:23] == 8'hFF) && (f[22:0] != 23'd0);
  endfunction

  // single float -> signed fixed with FRAC fractional bits, saturating
  function automatic fx_t f2fx(input logic [31:0] f);
    int         sh;
    logic [FXW-1:0] mag;
    sh = int'(f[30:23]) - (150 - FRAC);
    if (f[30:23] == 8'd0)
      mag = '0;
    else if (f[30:23] == 8'hFF || sh > FXW - 25)
      mag = {1'b0, {(FXW-1){1'b1}}};
    else if (sh >= 0)
      mag = FXW'({1'b1, f[22:0]}) << sh;
    else if (sh > -24)
      mag = FXW'({1'b1, f[22:0]}) >> (-sh);
    else
      mag = '0;
    return f[31] ? -$signed(mag) : $signed(mag);
  endfunction

  // wide fixed -> unsigned code with CODE_FRAC fractional bits, clamped
  function automatic code_t fx2code(input wide_t s);
    wide_t q;
    q = s >>> (FRAC - CODE_FRAC);
    if (s < 0)
      return '0;
    else if (q > wide_t'(2 ** CODE_W - 1))
      return '1;
    else
      return q[CODE_W-1:0];
  endfunction

endpackage

// File: rtl/dac_chmap_cfg.sv
module dac_chmap_cfg #(
  parameter int NUM_CH = 32,
  parameter int IDX_W  = 8,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [1:0]       field,
  input  logic [CH_W-1:0]  wch,
  input  logic [31:0]      wdata,
  input  logic             commit,
  input  logic [CH_W-1:0]  rch,
  output logic [IDX_W-1:0] rd_idx,
  output logic [31:0]      rd_gain,
  output logic [31:0]      rd_off
);

  logic [IDX_W-1:0] idx_s [NUM_CH];
  logic [31:0]      gain_s [NUM_CH];
  logic [31:0]      off_s [NUM_CH];
  logic [IDX_W-1:0] idx_a [NUM_CH];
  logic [31:0]      gain_a [NUM_CH];
  logic [31:0]      off_a [NUM_CH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CH; c++) begin
        idx_s[c] <= '0; gain_s[c] <= '0; off_s[c] <= '0;
        idx_a[c] <= '0; gain_a[c] <= '0; off_a[c] <= '0;
      end
    end else begin
      if (we) begin
        case (field)
          2'd0:    idx_s[wch]  <= wdata[IDX_W-1:0];
          2'd1:    gain_s[wch] <= wdata;
          2'd2:    off_s[wch]  <= wdata;
          default: ;
        endcase
      end
      if (commit) begin
        for (int c = 0; c < NUM_CH; c++) begin
          idx_a[c]  <= idx_s[c];
          gain_a[c] <= gain_s[c];
          off_a[c]  <= off_s[c];
        end
      end
    end
  end

  assign rd_idx  = idx_a[rch];
  assign rd_gain = gain_a[rch];
  assign rd_off  = off_a[rch];

endmodule

// File: rtl/dac_chmap_dp.sv
module dac_chmap_dp
  import dac_chmap_pkg::*;
#(
  parameter int CH_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_vld,
  input  logic [CH_W-1:0] in_ch,
  input  logic [31:0]     in_sig,
  input  logic [31:0]     in_gain,
  input  logic [31:0]     in_off,
  input  logic            in_zero,
  output logic            wr_en,
  output logic [CH_W-1:0] wr_ch,
  output code_t           wr_code,
  output logic            wr_nan,
  output logic            wr_zero
);

  // stage A: float to fixed
  logic            a_vld, a_nan, a_zero;
  logic [CH_W-1:0] a_ch;
  fx_t             a_in, a_gain, a_off;
  // stage B: multiply-add
  logic            b_vld, b_nan, b_zero;
  logic [CH_W-1:0] b_ch;
  wide_t           b_sum;
  wide_t           prod;

  assign prod = wide_t'(a_in) * wide_t'(a_gain);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_vld <= 1'b0; a_nan <= 1'b0; a_zero <= 1'b0; a_ch <= '0;
      a_in  <= '0;   a_gain <= '0;  a_off  <= '0;
      b_vld <= 1'b0; b_nan <= 1'b0; b_zero <= 1'b0; b_ch <= '0;
      b_sum <= '0;
    end else begin
      a_vld  <= in_vld;
      a_ch   <= in_ch;
      a_zero <= in_zero;
      a_nan  <= f_is_nan(in_sig) | f_is_nan(in_gain) | f_is_nan(in_off);
      a_in   <= f2fx(in_sig);
      a_gain <= f2fx(in_gain);
      a_off  <= f2fx(in_off);
      b_vld  <= a_vld;
      b_ch   <= a_ch;
      b_zero <= a_zero;
      b_nan  <= a_nan;
      b_sum  <= (prod >>> FRAC) + wide_t'(a_off);
    end
  end

  assign wr_en   = b_vld;
  assign wr_ch   = b_ch;
  assign wr_nan  = b_nan;
  assign wr_zero = b_zero;
  assign wr_code = (b_nan || b_zero) ? '0 : fx2code(b_sum);

endmodule

// File: rtl/dac_chmap.sv
module dac_chmap
  import dac_chmap_pkg::*;
#(
  parameter int NUM_SIG  = 8,
  parameter int BANK_CH  = 16,
  parameter int NUM_BANK = 2,
  parameter int IDX_W    = 8,
  localparam int NUM_CH  = BANK_CH * NUM_BANK,
  localparam int CH_W    = $clog2(NUM_CH),
  localparam int SIG_W   = $clog2(NUM_SIG)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sync_i,
  input  logic                     park_i,
  input  logic [NUM_SIG*32-1:0]    sig_bus_i,
  input  logic                     cfg_we_i,
  input  logic [1:0]               cfg_field_i,
  input  logic [CH_W-1:0]          cfg_ch_i,
  input  logic [31:0]              cfg_data_i,
  output logic [NUM_CH*CODE_W-1:0] ch_code_o,
  output logic [NUM_BANK-1:0]      conv_o
);

  logic            busy_q, park_q, start;
  logic [CH_W-1:0] cnt_q;
  logic [31:0]     snap_q [NUM_SIG];
  logic [IDX_W-1:0] rd_idx;
  logic [31:0]     rd_gain, rd_off, src;
  logic            wr_en, wr_nan, wr_zero;
  logic [CH_W-1:0] wr_ch;
  code_t           wr_code;
  code_t           stage_q [NUM_CH];

  assign start = sync_i && !busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      park_q <= 1'b0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      park_q <= park_i;
    end else if (busy_q) begin
      if (cnt_q == CH_W'(NUM_CH - 1)) busy_q <= 1'b0;
      else                             cnt_q  <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (start)
      for (int i = 0; i < NUM_SIG; i++) snap_q[i] <= sig_bus_i[i*32 +: 32];
  end

  dac_chmap_cfg #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) cfg_i (
    .clk(clk), .rst_n(rst_n), .we(cfg_we_i), .field(cfg_field_i),
    .wch(cfg_ch_i), .wdata(cfg_data_i), .commit(start), .rch(cnt_q),
    .rd_idx(rd_idx), .rd_gain(rd_gain), .rd_off(rd_off)
  );

  assign src = (int'(rd_idx) < NUM_SIG) ? snap_q[rd_idx[SIG_W-1:0]] : 32'd0;

  dac_chmap_dp #(.CH_W(CH_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .in_vld(busy_q), .in_ch(cnt_q),
    .in_sig(src), .in_gain(rd_gain), .in_off(rd_off), .in_zero(park_q),
    .wr_en(wr_en), .wr_ch(wr_ch), .wr_code(wr_code),
    .wr_nan(wr_nan), .wr_zero(wr_zero)
  );

  always_ff @(posedge clk) begin
    if (wr_en) stage_q[wr_ch] <= wr_code;
  end

  for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
    localparam int LAST = b * BANK_CH + BANK_CH - 1;
    logic  done_r, conv_r;
    code_t bank_q [BANK_CH];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        done_r <= 1'b0;
        conv_r <= 1'b0;
        for (int k = 0; k < BANK_CH; k++) bank_q[k] <= '0;
      end else begin
        done_r <= wr_en && (wr_ch == CH_W'(LAST));
        conv_r <= done_r;
        if (done_r)
          for (int k = 0; k < BANK_CH; k++) bank_q[k] <= stage_q[b*BANK_CH + k];
      end
    end

    assign conv_o[b] = conv_r;
    for (genvar k = 0; k < BANK_CH; k++) begin : g_ch
      assign ch_code_o[(b*BANK_CH + k)*CODE_W +: CODE_W] = bank_q[k];
    end
  end

endmodule

// File: rtl/dac_chmap_chk.sv
module dac_chmap_chk #(
  parameter int NUM_CH   = 32,
  parameter int NUM_BANK = 2,
  parameter int BANK_CH  = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 sync_i,
  input logic                 busy,
  input logic                 start,
  input logic [NUM_BANK-1:0]  conv,
  input logic                 wr_en,
  input logic                 wr_nan,
  input logic                 wr_zero,
  input logic [15:0]          wr_code,
  input logic [NUM_CH*16-1:0] codes
);

  for (genvar b = 0; b < NUM_BANK; b++) begin : g_b
    AST_CONV_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      conv[b] |=> !conv[b]);                                                // R8
    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !conv[b] |-> $stable(codes[b*BANK_CH*16 +: BANK_CH*16]));              // R7
  end

  AST_STROBES_APART: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(conv));                                                       // R8
  AST_NAN_CODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_nan |-> wr_code == 16'd0);                                 // R4
  AST_PARK_CODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_zero |-> wr_code == 16'd0);                                // R9
  AST_SYNC_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    sync_i && busy |-> !start);                                            // R10
  AST_START_SWEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);                                                       // R10

endmodule

bind dac_chmap dac_chmap_chk #(.NUM_CH(NUM_CH), .NUM_BANK(NUM_BANK), .BANK_CH(BANK_CH)) chk_i (
  .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .busy(busy_q), .start(start),
  .conv(conv_o), .wr_en(wr_en), .wr_nan(wr_nan), .wr_zero(wr_zero),
  .wr_code(wr_code), .codes(ch_code_o)
);

// File: tb/dac_chmap_tb_top.sv
module dac_chmap_tb_top;

  localparam int NSIG = 8;
  localparam int NCH  = 32;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             sync_i = 1'b0, park_i = 1'b0;
  logic [NSIG*32-1:0] sig_bus = '0;
  logic             cfg_we = 1'b0;
  logic [1:0]       cfg_field = '0;
  logic [4:0]       cfg_ch = '0;
  logic [31:0]      cfg_data = '0;
  logic [NCH*16-1:0] codes;
  logic [1:0]       conv;

  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  dac_chmap dut_i (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .park_i(park_i),
    .sig_bus_i(sig_bus), .cfg_we_i(cfg_we), .cfg_field_i(cfg_field),
    .cfg_ch_i(cfg_ch), .cfg_data_i(cfg_data), .ch_code_o(codes), .conv_o(conv)
  );

  // exactly representable reals only
  function automatic logic [31:0] r2f(input real r);
    logic [63:0] d;
    logic [10:0] e;
    if (r == 0.0) return 32'd0;
    d = $realtobits(r);
    e = d[62:52] - 11'd896;
    return {d[63], e[7:0], d[51:29]};
  endfunction

  function automatic int exp_code(input real x, input real g, input real o);
    real v;
    v = (x * g + o) * 2048.0;
    if (v < 0.0) return 0;
    if (v >= 65536.0) return 65535;
    return int'($floor(v));
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int code(input int ch);
    return int'(codes[ch*16 +: 16]);
  endfunction

  task automatic set_sig(input int i, input logic [31:0] v);
    sig_bus[i*32 +: 32] = v;
  endtask

  task automatic wr(input int ch, input int field, input logic [31:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = 5'(ch); cfg_field = 2'(field); cfg_data = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic map(input int ch, input int idx, input real g, input real o);
    wr(ch, 0, 32'(idx));
    wr(ch, 1, r2f(g));
    wr(ch, 2, r2f(o));
  endtask

  task automatic launch;
    @(negedge clk); sync_i = 1'b1;
    @(negedge clk); sync_i = 1'b0;   // now just after accepting edge
  endtask

  // R8: strobe timing relative to the accepting edge
  task automatic wait_done;
    repeat (18) @(negedge clk);
    check("R8 no strobe before bank0", int'(conv), 0);
    @(negedge clk);
    check("R8 bank0 strobe at edge 19", int'(conv), 1);
    repeat (15) @(negedge clk);
    check("R8 idle between strobes", int'(conv), 0);
    @(negedge clk);
    check("R8 bank1 strobe at edge 35", int'(conv), 2);
    @(negedge clk);
    check("R8 strobe one cycle", int'(conv), 0);
  endtask

  task automatic t_reset;
    for (int c = 0; c < NCH; c++) check("R11 reset code", code(c), 0);
    check("R11 reset strobes", int'(conv), 0);
  endtask

  task automatic t_basic;
    map(0, 0, 2.0, 0.5);
    map(5, 2, 0.5, 1.0);
    map(17, 1, -1.0, 0.0);
    map(31, 3, 4.0, 0.125);
    launch(); wait_done();
    check("R1 R2 ch0", code(0), exp_code(1.5, 2.0, 0.5));
    check("R1 R2 ch5", code(5), exp_code(10.0, 0.5, 1.0));
    check("R1 R2 ch17", code(17), exp_code(-2.0, -1.0, 0.0));
    check("R1 R2 ch31", code(31), exp_code(0.25, 4.0, 0.125));
    check("R2 unmapped ch1", code(1), 0);
  endtask

  task automatic t_sat;
    map(2, 2, 4.0, 0.0);
    map(3, 1, 1.0, 0.0);
    map(4, 4, 1.0, 0.0);
    map(20, 5, 1.0, 100.0);
    map(6, 3, 128.0, 0.0);
    map(7, 7, 1.0, 0.0);
    map(21, 7, 1.0, 0.49951171875);
    map(8, 6, 1.0, 5.0);
    map(9, 0, 1.0, 0.0);
    wr(9, 2, 32'h7FC00000);
    launch(); wait_done();
    check("R3 above 32", code(2), 65535);
    check("R3 negative", code(3), 0);
    check("R3 plus inf", code(4), 65535);
    check("R3 minus inf", code(20), 0);
    check("R3 exactly 32", code(6), 65535);
    check("R2 31.5", code(7), exp_code(31.5, 1.0, 0.0));
    check("R2 top code", code(21), 65535);
    check("R4 nan source", code(8), 0);
    check("R4 nan offset", code(9), 0);
  endtask

  task automatic t_oor;
    map(10, 200, 3.0, 1.5);
    map(11, 8, 3.0, 0.25);
    launch(); wait_done();
    check("R5 index 200", code(10), exp_code(0.0, 3.0, 1.5));
    check("R5 index NUM_SIG", code(11), exp_code(0.0, 3.0, 0.25));
  endtask

  task automatic t_shadow;
    map(0, 0, 1.0, 0.0);
    wr(12, 3, r2f(9.0));   // field 3: no effect
    repeat (40) @(negedge clk);
    check("R6 no change before sync", code(0), exp_code(1.5, 2.0, 0.5));
    launch(); wait_done();
    check("R6 applied at sync", code(0), exp_code(1.5, 1.0, 0.0));
    check("R6 field 3 ignored", code(12), 0);
  endtask

  task automatic t_snapshot;
    launch();
    set_sig(0, r2f(3.0));
    wait_done();
    check("R7 bus sampled at sync", code(0), exp_code(1.5, 1.0, 0.0));
    repeat (5) @(negedge clk);
    check("R7 hold between updates", code(0), exp_code(1.5, 1.0, 0.0));
    launch(); wait_done();
    check("R7 next sample", code(0), exp_code(3.0, 1.0, 0.0));
  endtask

  task automatic t_park;
    @(negedge clk); park_i = 1'b1; sync_i = 1'b1;
    @(negedge clk); park_i = 1'b0; sync_i = 1'b0;
    wait_done();
    check("R9 parked ch0", code(0), 0);
    check("R9 parked ch5", code(5), 0);
    check("R9 parked ch31", code(31), 0);
    launch(); wait_done();
    check("R9 resumes", code(0), exp_code(3.0, 1.0, 0.0));
  endtask

  task automatic t_busy;
    int p0 = 0, p1 = 0;
    launch();
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      sync_i = (i == 5) || (i == 30);
      if (conv[0]) p0++;
      if (conv[1]) p1++;
    end
    sync_i = 1'b0;
    check("R10 one bank0 strobe", p0, 1);
    check("R10 one bank1 strobe", p1, 1);
  endtask

  initial begin
    set_sig(0, r2f(1.5));
    set_sig(1, r2f(-2.0));
    set_sig(2, r2f(10.0));
    set_sig(3, r2f(0.25));
    set_sig(4, 32'h7F800000);
    set_sig(5, 32'hFF800000);
    set_sig(6, 32'h7FC00000);
    set_sig(7, r2f(31.5));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_sat();
    t_oor();
    t_shadow();
    t_snapshot();
    t_park();
    t_busy();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #500us;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule